// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block is the programming face of a sixteen-input interrupt router. A bus master reaches every internal register through two bus-visible locations: a select register, which holds a register index, and a data window, which reads or writes whichever 32-bit register that index names. The indexed space holds an identification register, a read-only version word, a read-only arbitration word, and one 64-bit redirection entry per input pin, each entry split into two 32-bit halves.

All entries are exported side by side to the delivery logic, which decides what to do with a pin's vector, destination and mode. The block itself watches the pin levels for one purpose only. When a level-triggered pin rises while its entry is masked, the block remembers a pending interrupt. When software later unmasks that entry, the block clears the pending flag and, if the pin is still high, emits a one-cycle re-delivery request for that pin so that the interrupt is not lost.

The bus is a simple valid/write/address/size/data request with a registered response one cycle later.

Top module: `irq_route_regfile`

## Requirements
- R1: Every cycle with `req_valid_i` high is answered one cycle later by `rsp_valid_o` high; a read's data appears on `rsp_rdata_o` in that same response cycle, and `rsp_valid_o` is low otherwise.
- R2: Only requests with `req_bytes_i` equal to 4 at address 0x000 (select) or 0x010 (window) take effect; any other read returns 0 and any other write changes no state.
- R3: The select register keeps all 32 written bits and reads them back at address 0x000; only its bits 7:0 choose the indexed register.
- R4: Index 0x00 is the identification register: a write keeps only bits 27:24 and clears the rest; it reads back the kept value.
- R5: Index 0x01 reads the constant 0x0010_0011 (pin count 16 in bits 23:16, code 0x11 in bits 7:0); writes to it are ignored.
- R6: Index 0x02 reads the current identification value; writes to it are ignored.
- R7: Pin p's entry is reached at index 0x10+2p (entry bits 31:0) and 0x11+2p (bits 63:32); a write replaces only the addressed half, and `entries_o[64p +: 64]` shows the entry.
- R8: After reset every entry is 0x0001_0000_0001_0000 (bit 16, the mask bit, set), the identification and select registers are 0, and no pin is pending.
- R9: Any index other than 0x00, 0x01, 0x02 and 0x10 to 0x2F reads as 0.
- R10: A pin is pending after a cycle in which its level is 1 and was 0 the cycle before (0 assumed at reset) while its entry, as it stood before any write that cycle, has mask bit 16 and level-trigger bit 15 both set.
- R11: A window write to either half of pin p's entry that leaves bit 16 clear while p is pending (including a rise flagged in the same cycle) clears the pending flag; `redeliver_o[p]` is then high for exactly the following cycle if the pin level was 1 in the write cycle, and the interrupt is dropped otherwise.
- R12: Rises on edge-triggered (bit 15 clear) or unmasked entries never make a pin pending, so a later unmask produces no re-delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset of the request |
| req_bytes_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data |
| pin_level_i | input | 16 | Current interrupt pin levels |
| entries_o | output | 1024 | All redirection entries, pin p at bits 64p+63:64p |
| redeliver_o | output | 16 | One-cycle re-delivery request per pin |

## Verification
Two functions can meet in one cycle: a pin's rising edge that would set its pending flag, and a window write that unmasks the same pin's entry. The bench provokes this by raising the pin in exactly the cycle the unmask write is presented, and expects a re-delivery pulse with the pending flag gone afterwards, judged against a behavioural model that applies the rule stated in R10 and R11. A long randomised stretch then mixes pin toggles, select changes and half-entry writes so that this coincidence and its neighbours (a write that keeps the mask, a pin that falls in the unmask cycle) recur many times under the same model.

// File: rtl/irr_pkg.sv
package irr_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ENTRY_W    = 64;
    localparam int unsigned IDX_W      = 8;

    localparam logic [IDX_W-1:0] IDX_IDENT  = 8'h00;
    localparam logic [IDX_W-1:0] IDX_VERSION = 8'h01;
    localparam logic [IDX_W-1:0] IDX_ARBIT  = 8'h02;
    localparam int unsigned      IDX_ENTRY_BASE = 16;

    localparam int unsigned OFS_SELECT = 'h00;
    localparam int unsigned OFS_WINDOW = 'h10;
    localparam int unsigned ACCESS_BYTES = 4;

    localparam int unsigned MASK_BIT  = 16;
    localparam int unsigned LEVEL_BIT = 15;
    localparam int unsigned IDENT_LSB = 24;
    localparam int unsigned IDENT_W   = 4;
    localparam int unsigned COUNT_LSB = 16;
    localparam logic [7:0]  VERSION_CODE = 8'h11;

    localparam logic [ENTRY_W-1:0] ENTRY_RESET = 64'h0001_0000_0001_0000;

    typedef struct packed {
        logic              wr_select;
        logic              wr_window;
        logic              rd_select;
        logic              rd_window;
        logic [DATA_W-1:0] wdata;
    } access_t;

    function automatic logic [DATA_W-1:0] version_word(input int unsigned pins);
        logic [DATA_W-1:0] w;
        w = DATA_W'(pins) << COUNT_LSB;
        w[7:0] = w[7:0] | VERSION_CODE;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] ident_keep(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] m;
        m = ((DATA_W'(1) << IDENT_W) - 1) << IDENT_LSB;
        return d & m;
    endfunction

endpackage

// File: rtl/irr_window.sv
module irr_window
    import irr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_bytes,
    input  logic [DATA_W-1:0] req_wdata,
    output access_t           acc,
    output logic [DATA_W-1:0] select_q
);

    logic legal;
    logic at_select;
    logic at_window;

    assign at_select = (req_addr == ADDR_W'(OFS_SELECT));
    assign at_window = (req_addr == ADDR_W'(OFS_WINDOW));
    assign legal     = req_valid && (req_bytes == 3'(ACCESS_BYTES)) && (at_select || at_window);

    always_comb begin
        acc.wr_select = legal &&  req_write && at_select;
        acc.wr_window = legal &&  req_write && at_window;
        acc.rd_select = legal && !req_write && at_select;
        acc.rd_window = legal && !req_write && at_window;
        acc.wdata     = req_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            select_q <= '0;
        end else if (acc.wr_select) begin
            select_q <= req_wdata;
        end
    end

    // R2: an access of the wrong size never moves the select register
    p_select_size_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid) && $past(req_bytes) != 3'(ACCESS_BYTES)) |-> $stable(select_q));

endmodule

// File: rtl/irr_entry.sv
module irr_entry
    import irr_pkg::*;
#(
    parameter int unsigned ENTRY_IDX = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               win_write,
    input  logic [IDX_W-1:0]   win_index,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               pin_level,
    output logic [ENTRY_W-1:0] entry_q,
    output logic               redeliver_q
);

    localparam logic [IDX_W-1:0] IDX_LO = IDX_W'(ENTRY_IDX);
    localparam logic [IDX_W-1:0] IDX_HI = IDX_W'(ENTRY_IDX + 1);

    logic               pending_q;
    logic               pin_prev_q;
    logic               hit_lo;
    logic               hit_hi;
    logic [ENTRY_W-1:0] entry_d;
    logic               rise;
    logic               set_pending;
    logic               eff_pending;
    logic               unmask_now;

    assign hit_lo = win_write && (win_index == IDX_LO);
    assign hit_hi = win_write && (win_index == IDX_HI);

    always_comb begin
        entry_d = entry_q;
        if (hit_lo) entry_d[31:0]  = wdata;
        if (hit_hi) entry_d[63:32] = wdata;
    end

    assign rise        = pin_level && !pin_prev_q;
    assign set_pending = rise && entry_q[MASK_BIT] && entry_q[LEVEL_BIT];
    assign eff_pending = pending_q || set_pending;
    assign unmask_now  = (hit_lo || hit_hi) && !entry_d[MASK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q     <= ENTRY_RESET;
            pending_q   <= 1'b0;
            pin_prev_q  <= 1'b0;
            redeliver_q <= 1'b0;
        end else begin
            entry_q     <= entry_d;
            pending_q   <= unmask_now ? 1'b0 : eff_pending;
            pin_prev_q  <= pin_level;
            redeliver_q <= unmask_now && eff_pending && pin_level;
        end
    end

    // R10: a pending pin always belongs to a masked entry
    p_pending_masked_r10: assert property (@(posedge clk) disable iff (rst)
        pending_q |-> entry_q[MASK_BIT]);

    // R11: a re-delivery follows a cycle with the pin high and leaves the entry unmasked
    p_redeliver_ok_r11: assert property (@(posedge clk) disable iff (rst)
        redeliver_q |-> (!entry_q[MASK_BIT] && $past(pin_level)));

    // R7: without a write to this entry it holds its value
    p_entry_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(hit_lo || hit_hi) |-> $stable(entry_q));

    // R7: a low-half write leaves the high half untouched
    p_half_keep_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(hit_lo) && !$past(hit_hi)) |-> (entry_q[63:32] == $past(entry_q[63:32])));

endmodule

// File: rtl/irr_readmux.sv
module irr_readmux
    import irr_pkg::*;
#(
    parameter int unsigned PINS = 16
) (
    input  logic [IDX_W-1:0]        index,
    input  logic [DATA_W-1:0]       ident,
    input  logic [PINS*ENTRY_W-1:0] entries,
    output logic [DATA_W-1:0]       word
);

    localparam logic [DATA_W-1:0] VERSION = version_word(PINS);

    always_comb begin
        word = '0;
        if (index == IDX_IDENT || index == IDX_ARBIT) begin
            word = ident;
        end else if (index == IDX_VERSION) begin
            word = VERSION;
        end else begin
            for (int p = 0; p < int'(PINS); p++) begin
                if (index == IDX_W'(IDX_ENTRY_BASE + 2*p))
                    word = entries[p*ENTRY_W +: DATA_W];
                if (index == IDX_W'(IDX_ENTRY_BASE + 2*p + 1))
                    word = entries[p*ENTRY_W + DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irr_pkg::*;
#(
    parameter int unsigned PINS   = 16,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid_i,
    input  logic                    req_write_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic [2:0]              req_bytes_i,
    input  logic [DATA_W-1:0]       req_wdata_i,
    output logic                    rsp_valid_o,
    output logic [DATA_W-1:0]       rsp_rdata_o,
    input  logic [PINS-1:0]         pin_level_i,
    output logic [PINS*ENTRY_W-1:0] entries_o,
    output logic [PINS-1:0]         redeliver_o
);

    access_t           acc;
    logic [DATA_W-1:0] select_q;
    logic [DATA_W-1:0] ident_q;
    logic [DATA_W-1:0] mux_word;
    logic [DATA_W-1:0] rdata_d;
    logic [IDX_W-1:0]  index;

    assign index = select_q[IDX_W-1:0];

    irr_window #(.ADDR_W(ADDR_W)) u_window (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid_i),
        .req_write (req_write_i),
        .req_addr  (req_addr_i),
        .req_bytes (req_bytes_i),
        .req_wdata (req_wdata_i),
        .acc       (acc),
        .select_q  (select_q)
    );

    for (genvar p = 0; p < int'(PINS); p++) begin : g_entry
        irr_entry #(.ENTRY_IDX(IDX_ENTRY_BASE + 2*p)) u_entry (
            .clk         (clk),
            .rst         (rst),
            .win_write   (acc.wr_window),
            .win_index   (index),
            .wdata       (acc.wdata),
            .pin_level   (pin_level_i[p]),
            .entry_q     (entries_o[p*ENTRY_W +: ENTRY_W]),
            .redeliver_q (redeliver_o[p])
        );
    end

    irr_readmux #(.PINS(PINS)) u_readmux (
        .index   (index),
        .ident   (ident_q),
        .entries (entries_o),
        .word    (mux_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ident_q <= '0;
        end else if (acc.wr_window && index == IDX_IDENT) begin
            ident_q <= ident_keep(acc.wdata);
        end
    end

    always_comb begin
        rdata_d = '0;
        if (acc.rd_select)      rdata_d = select_q;
        else if (acc.rd_window) rdata_d = mux_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_rdata_o <= rdata_d;
        end
    end

    // R1: one response for each request, one cycle later
    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid_i) |-> rsp_valid_o);

    // R2: a read of the wrong size answers zero
    p_bad_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid_i) && !$past(req_write_i) && $past(req_bytes_i) != 3'(ACCESS_BYTES))
            |-> (rsp_rdata_o == '0));

    // R4: the identification register only ever holds its field bits
    p_ident_field_r4: assert property (@(posedge clk) disable iff (rst)
        (ident_q == ident_keep(ident_q)));

endmodule

// File: tb/test_irq_route_regfile.sv
`timescale 1ns/1ps
module test_irq_route_regfile;

    localparam int PINS = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [11:0]          req_addr = '0;
    logic [2:0]           req_bytes = 3'd4;
    logic [31:0]          req_wdata = '0;
    logic                 rsp_valid;
    logic [31:0]          rsp_rdata;
    logic [PINS-1:0]      pins = '0;
    logic [PINS*64-1:0]   entries;
    logic [PINS-1:0]      redeliver;

    always #2.5 clk = ~clk;

    irq_route_regfile i_irq_route_regfile (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_bytes_i(req_bytes), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .pin_level_i(pins), .entries_o(entries), .redeliver_o(redeliver)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_ent [PINS];
    bit          m_pend [PINS];
    logic [PINS-1:0] m_prev;
    logic [31:0] m_sel, m_id;
    bit          exp_rv, started, in_rst;
    logic [31:0] exp_rd;
    logic [PINS-1:0] exp_redel;
    string       cur_tag = "R8", exp_tag = "R8";
    int          compared = 0, mismatched = 0;

    function automatic logic [31:0] mread(input logic [7:0] idx);
        if (idx == 8'h00 || idx == 8'h02) return m_id;
        if (idx == 8'h01) return 32'h0010_0011;
        if (idx >= 8'h10 && idx < 8'h30)
            return idx[0] ? m_ent[(idx - 16) / 2][63:32] : m_ent[(idx - 16) / 2][31:0];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            for (int p = 0; p < PINS; p++) begin
                m_ent[p] = 64'h0001_0000_0001_0000;
                m_pend[p] = 0;
            end
            m_prev = '0; m_sel = '0; m_id = '0;
            exp_rv = 0; exp_rd = '0; exp_redel = '0; in_rst = 1; exp_tag = "R8";
        end else begin
            bit ok;
            int hitp;
            logic [PINS-1:0] setp;
            ok = req_valid && req_bytes == 3'd4 && (req_addr == 12'h000 || req_addr == 12'h010);
            exp_rv = req_valid;
            exp_rd = '0;
            exp_tag = cur_tag;
            if (ok && !req_write) exp_rd = (req_addr == 12'h000) ? m_sel : mread(m_sel[7:0]);
            for (int p = 0; p < PINS; p++)
                setp[p] = pins[p] & ~m_prev[p] & m_ent[p][16] & m_ent[p][15];
            hitp = -1;
            if (ok && req_write) begin
                if (req_addr == 12'h000) m_sel = req_wdata;
                else if (m_sel[7:0] == 8'h00) m_id = req_wdata & 32'h0F00_0000;
                else if (m_sel[7:0] >= 8'h10 && m_sel[7:0] < 8'h30) begin
                    hitp = (int'(m_sel[7:0]) - 16) / 2;
                    if (m_sel[0]) m_ent[hitp][63:32] = req_wdata;
                    else          m_ent[hitp][31:0]  = req_wdata;
                end
            end
            for (int p = 0; p < PINS; p++) begin
                bit eff;
                eff = m_pend[p] | setp[p];
                exp_redel[p] = 1'b0;
                if (p == hitp && !m_ent[p][16] && eff) begin
                    exp_redel[p] = pins[p];
                    eff = 0;
                end
                m_pend[p] = eff;
            end
            m_prev = pins;
            in_rst = 0;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check("R1", 64'(rsp_valid), 64'(exp_rv));
            if (exp_rv) check(exp_tag, 64'(rsp_rdata), 64'(exp_rd));
            check("R11", 64'(redeliver), 64'(exp_redel));
            for (int p = 0; p < PINS; p++)
                check(in_rst ? "R8" : "R7", entries[p*64 +: 64], m_ent[p]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic xfer(input string tag, input bit w, input logic [11:0] a,
                        input logic [2:0] b, input logic [31:0] d);
        @(negedge clk);
        cur_tag = tag; req_valid = 1; req_write = w; req_addr = a; req_bytes = b; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wsel(input string tag, input logic [31:0] d);
        xfer(tag, 1, 12'h000, 3'd4, d);
    endtask
    task automatic wwin(input string tag, input logic [31:0] d);
        xfer(tag, 1, 12'h010, 3'd4, d);
    endtask
    task automatic rwin(input string tag);
        xfer(tag, 0, 12'h010, 3'd4, 32'h0);
    endtask
    task automatic setpins(input logic [PINS-1:0] v);
        @(negedge clk);
        pins = v;
        @(negedge clk);
    endtask

    bit done = 0;

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R8 reset state and R3 select readback
        xfer("R3", 0, 12'h000, 3'd4, 0);
        wsel("R8", 32'h16); rwin("R8");
        // R5 version, write ignored
        wsel("R5", 32'h01); rwin("R5"); wwin("R5", 32'hFFFF_FFFF); rwin("R5");
        // R4 identification
        wsel("R4", 32'h00); wwin("R4", 32'hFFFF_FFFF); rwin("R4");
        // R6 arbitration mirrors id, write ignored
        wsel("R6", 32'h02); rwin("R6"); wwin("R6", 32'h0); rwin("R6");
        wsel("R6", 32'h00); rwin("R6");
        // R3 upper select bits kept but ignored for decode
        wsel("R3", 32'hABCD_0016); xfer("R3", 0, 12'h000, 3'd4, 0); rwin("R3");
        // R7 halves of pin 3
        wsel("R7", 32'h16); wwin("R7", 32'h0001_8035);
        wsel("R7", 32'h17); wwin("R7", 32'hFF00_0000); rwin("R7");
        wsel("R7", 32'h16); rwin("R7");
        // R9 unmatched indices
        wsel("R9", 32'h03); rwin("R9"); wsel("R9", 32'h30); rwin("R9");
        wsel("R9", 32'h0F); rwin("R9"); wsel("R9", 32'hFF); rwin("R9");
        // R2 illegal sizes and offsets
        wsel("R2", 32'h16);
        xfer("R2", 1, 12'h010, 3'd2, 32'h0000_0000);
        xfer("R2", 1, 12'h004, 3'd4, 32'h0000_0000);
        xfer("R2", 1, 12'h000, 3'd1, 32'h0000_0001);
        xfer("R2", 0, 12'h010, 3'd1, 0);
        xfer("R2", 0, 12'h020, 3'd4, 0);
        rwin("R2");
        // R10/R11 pending then re-delivery on unmask (pin 3, level, masked)
        setpins(16'h0008);
        wsel("R11", 32'h16); wwin("R11", 32'h0000_8035);
        // R11 dropped: pending, pin falls, unmask yields nothing
        wwin("R11", 32'h0001_8035);
        setpins(16'h0000); setpins(16'h0008); setpins(16'h0000);
        wwin("R11", 32'h0000_8035);
        wwin("R11", 32'h0001_8035); setpins(16'h0008);
        setpins(16'h0000);
        // R12 edge-triggered pin 5, unmasked level pin 6
        wsel("R12", 32'h1A); wwin("R12", 32'h0001_0040);
        setpins(16'h0020); wwin("R12", 32'h0000_0040);
        wsel("R12", 32'h1C); wwin("R12", 32'h0000_8041);
        setpins(16'h0060); wwin("R12", 32'h0001_8041); wwin("R12", 32'h0000_8041);
        setpins(16'h0000);
        // R11 coincidence: pin 7 rises in the unmask write cycle
        wsel("R11", 32'h1E); wwin("R11", 32'h0001_8042);
        @(negedge clk);
        cur_tag = "R11"; pins = 16'h0080;
        req_valid = 1; req_write = 1; req_addr = 12'h010; req_bytes = 3'd4; req_wdata = 32'h0000_8042;
        @(negedge clk); req_valid = 0;
        repeat (2) @(negedge clk);
        // R11 high-half write keeps mask, then low-half unmask (pin 8)
        wsel("R11", 32'h20); wwin("R11", 32'h0001_8043);
        setpins(16'h0180);
        wsel("R11", 32'h21); wwin("R11", 32'h0100_0000);
        wsel("R11", 32'h20); wwin("R11", 32'h0000_8043);
        // random mix, R10 R11 R7
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cur_tag = "R10";
            if ($urandom_range(0, 3) == 0) pins = 16'($urandom);
            req_valid = $urandom_range(0, 1) == 1;
            req_write = $urandom_range(0, 3) != 0;
            req_bytes = ($urandom_range(0, 15) == 0) ? 3'd2 : 3'd4;
            if ($urandom_range(0, 4) == 0) begin
                req_addr = 12'h000;
                req_wdata = 32'(8'h10 + $urandom_range(0, 33));
            end else begin
                req_addr = 12'h010;
                req_wdata = ($urandom & 32'hFF00_80FF) | ($urandom_range(0, 1) << 16);
            end
        end
        @(negedge clk); req_valid = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule